// File: doc/BRIEF.md
# Set-Associative Tag Lookup Engine

This block is the tag side of one cache bank. Each cycle it can take one request, made of a set index, a tag and a read/write flag. It compares the tag against every way of the addressed set. One cycle later it reports the following:

- whether the request hit, and in which way;
- the lowest-index empty way;
- the replacement candidate;
- the way it allocated.

In the same edge it updates the tag array itself. A line is installed straight away on an allocating miss, and the dirty bits and per-way age counters are kept current.

A parameter selects the write policy. In write-back mode a write hit marks the line dirty. A miss that must replace a dirty line produces a memory write of that line's address, flagged as an eviction. In write-through mode every write goes straight out as a memory write, no line is ever dirty, and a write miss does not allocate. Memory addresses are rebuilt from the tag, the set and the bank number. Separate one-cycle pulses mark read misses and write misses, for event counters.

After reset the engine clears one line per cycle across the whole array. It accepts requests only once that sweep is done.

Top module: `tag_lookup_engine`

## Requirements
- R1: After reset is released, `ready` stays low for exactly SETS×WAYS cycles and then stays high. A request presented while `ready` is low produces no response and leaves every line unchanged.
- R2: A request accepted at one clock edge gives `rsp_valid`=1 after the next edge and not otherwise. `rsp_hit` is 1 exactly when a valid way of the set holds the request tag, and `rsp_hit_way` gives that way's index.
- R3: `rsp_free_found` is 1 when the set has an invalid way. `rsp_free_way` is then the lowest-index invalid way; otherwise it is 0.
- R4: `rsp_victim_way` is the way with the largest age counter. Ties go to the lowest index, so when all counters are equal the result is way 0.
- R5: On every accepted lookup the hit way's age counter is cleared. Every other valid way's counter goes up by one and stays at 2^AGE_W−1 once it gets there. Invalid ways keep their counters, and a newly installed line starts at age 0.
- R6: A read miss always allocates; a write miss allocates only in write-back mode. The line goes into the free way if one exists, otherwise into the victim, and `rsp_alloc_way` names it. The new line is valid, holds the request tag, and is dirty only for a write-back write miss.
- R7: In write-back mode a write hit sets that line's dirty bit and issues no memory write.
- R8: In write-through mode every accepted write issues a memory write of the request's own address, whether it hits or misses. No line becomes dirty and `mem_wr_evict` stays 0.
- R9: In write-back mode, an allocating miss with no free way whose victim is dirty issues a memory write of the victim's address, with `mem_wr_evict`=1.
- R10: A memory address has zeros in its low BYTE_BITS+WORD_BITS bits. Above those come BANK_BITS bits holding BANK_ID, then SET_BITS bits of set index, then the tag in the upper bits. A zero-width bank field contributes nothing.
- R11: `rd_miss_pulse` or `wr_miss_pulse` is 1 for exactly the response cycle of a missing read or write respectively, and is 0 on hits and in idle cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ready | output | 1 | Array sweep finished; requests accepted |
| req_valid | input | 1 | Request present |
| req_set | input | SET_BITS | Set index |
| req_tag | input | TAG_W | Request tag |
| req_write | input | 1 | 1 = write, 0 = read |
| rsp_valid | output | 1 | Lookup result valid |
| rsp_hit | output | 1 | Request hit |
| rsp_hit_way | output | WAY_BITS | Hitting way |
| rsp_free_found | output | 1 | Set had an invalid way |
| rsp_free_way | output | WAY_BITS | Lowest invalid way |
| rsp_victim_way | output | WAY_BITS | Oldest way |
| rsp_alloc_way | output | WAY_BITS | Way chosen for allocation |
| mem_wr_valid | output | 1 | Memory write issued |
| mem_wr_addr | output | ADDR_W | Memory write line address |
| mem_wr_evict | output | 1 | Memory write is a dirty-line eviction |
| rd_miss_pulse | output | 1 | Read miss event |
| wr_miss_pulse | output | 1 | Write miss event |

## Verification
The hardest state to reach from the ports is a saturated age counter that changes the victim. This needs a full set in which one way is hit repeatedly until the other ways' counters pin at their maximum, in a pattern where a wrapping counter would have picked a different way. A directed sequence fills one set in order and then hits way 0 six times, which forces that split. A second sequence fills a set with write misses and then misses once more, to reach a dirty eviction. Random traffic concentrated on a few sets with a small tag pool supplies the mix of hits, refills and evictions. Two instances, one write-back with a bank field and one write-through with no bank field, run the same stimulus.

// File: rtl/tag_lookup_pkg.sv
package tag_lookup_pkg;

    typedef enum logic [2:0] {
        OP_IDLE       = 3'd0,
        OP_READ_HIT   = 3'd1,
        OP_WRITE_HIT  = 3'd2,
        OP_READ_MISS  = 3'd3,
        OP_WRITE_MISS = 3'd4
    } op_e;

    // Places a field of the given width at the given bit position.
    // A field of width zero yields zero.
    function automatic logic [63:0] place_field(input logic [63:0] val,
                                                input int lsb,
                                                input int width);
        logic [63:0] mask;
        if (width <= 0) return 64'd0;
        mask = (64'd1 << width) - 64'd1;
        return (val & mask) << lsb;
    endfunction

    // Line address from its tag, set and bank fields.
    function automatic logic [63:0] line_addr(input logic [63:0] tag,
                                              input logic [63:0] set,
                                              input logic [63:0] bank,
                                              input int low_bits,
                                              input int bank_bits,
                                              input int set_bits,
                                              input int tag_bits);
        return place_field(bank, low_bits, bank_bits)
             | place_field(set,  low_bits + bank_bits, set_bits)
             | place_field(tag,  low_bits + bank_bits + set_bits, tag_bits);
    endfunction

endpackage

// File: rtl/tag_lookup_init.sv
module tag_lookup_init #(
    parameter int IDX_W = 5
) (
    input  logic             clk,
    input  logic             rst,
    output logic             busy,
    output logic [IDX_W-1:0] line_idx
);
    localparam logic [IDX_W-1:0] LAST = {IDX_W{1'b1}};

    always_ff @(posedge clk) begin
        if (rst) begin
            busy     <= 1'b1;
            line_idx <= '0;
        end else if (busy) begin
            line_idx <= line_idx + 1'b1;
            if (line_idx == LAST) busy <= 1'b0;
        end
    end
endmodule

// File: rtl/tag_lookup_way_cmp.sv
module tag_lookup_way_cmp #(
    parameter int TAG_W = 24
) (
    input  logic             way_valid,
    input  logic [TAG_W-1:0] way_tag,
    input  logic [TAG_W-1:0] req_tag,
    output logic             match
);
    assign match = way_valid && (way_tag == req_tag);
endmodule

// File: rtl/tag_lookup_pick.sv
module tag_lookup_pick #(
    parameter int WAYS  = 4,
    parameter int WAY_W = 2,
    parameter int AGE_W = 3
) (
    input  logic [WAYS-1:0]       valid,
    input  logic [WAYS*AGE_W-1:0] ages,
    output logic                  free_found,
    output logic [WAY_W-1:0]      free_way,
    output logic [WAY_W-1:0]      victim_way
);
    logic [AGE_W-1:0] best_age;

    // Lowest invalid way: scan from the top so lower indices win.
    always_comb begin
        free_found = 1'b0;
        free_way   = '0;
        for (int w = WAYS - 1; w >= 0; w--) begin
            if (!valid[w]) begin
                free_found = 1'b1;
                free_way   = WAY_W'(w);
            end
        end
    end

    // Oldest way: strictly greater replaces, so ties keep the lower index.
    always_comb begin
        victim_way = '0;
        best_age   = ages[AGE_W-1:0];
        for (int w = 1; w < WAYS; w++) begin
            if (ages[w*AGE_W +: AGE_W] > best_age) begin
                best_age   = ages[w*AGE_W +: AGE_W];
                victim_way = WAY_W'(w);
            end
        end
    end
endmodule

// File: rtl/tag_lookup_engine.sv
module tag_lookup_engine
    import tag_lookup_pkg::*;
#(
    parameter int ADDR_W     = 32,
    parameter int BYTE_BITS  = 2,
    parameter int WORD_BITS  = 2,
    parameter int BANK_BITS  = 1,
    parameter int BANK_ID    = 0,
    parameter int SET_BITS   = 3,
    parameter int WAY_BITS   = 2,
    parameter int AGE_W      = 3,
    parameter bit WRITE_BACK = 1'b1,
    parameter int TAG_W      = ADDR_W - BYTE_BITS - WORD_BITS - BANK_BITS - SET_BITS
) (
    input  logic                clk,
    input  logic                rst,
    output logic                ready,
    input  logic                req_valid,
    input  logic [SET_BITS-1:0] req_set,
    input  logic [TAG_W-1:0]    req_tag,
    input  logic                req_write,
    output logic                rsp_valid,
    output logic                rsp_hit,
    output logic [WAY_BITS-1:0] rsp_hit_way,
    output logic                rsp_free_found,
    output logic [WAY_BITS-1:0] rsp_free_way,
    output logic [WAY_BITS-1:0] rsp_victim_way,
    output logic [WAY_BITS-1:0] rsp_alloc_way,
    output logic                mem_wr_valid,
    output logic [ADDR_W-1:0]   mem_wr_addr,
    output logic                mem_wr_evict,
    output logic                rd_miss_pulse,
    output logic                wr_miss_pulse
);
    localparam int SETS     = 1 << SET_BITS;
    localparam int WAYS     = 1 << WAY_BITS;
    localparam int IDX_W    = SET_BITS + WAY_BITS;
    localparam int LOW_BITS = BYTE_BITS + WORD_BITS;
    localparam logic [AGE_W-1:0] AGE_MAX = {AGE_W{1'b1}};

    // Line state array
    logic [TAG_W-1:0] tag_q   [SETS][WAYS];
    logic [AGE_W-1:0] age_q   [SETS][WAYS];
    logic [WAYS-1:0]  valid_q [SETS];
    logic [WAYS-1:0]  dirty_q [SETS];

    // Initialization sweep
    logic             init_busy;
    logic [IDX_W-1:0] init_idx;

    tag_lookup_init #(.IDX_W(IDX_W)) u_init (
        .clk      (clk),
        .rst      (rst),
        .busy     (init_busy),
        .line_idx (init_idx)
    );

    assign ready = !init_busy;

    logic accept;
    assign accept = req_valid && ready;

    // Row read and per-way compare
    logic [WAYS-1:0]       row_valid;
    logic [WAYS-1:0]       row_dirty;
    logic [WAYS*AGE_W-1:0] row_ages;
    logic [WAYS-1:0]       hit_vec;

    assign row_valid = valid_q[req_set];
    assign row_dirty = dirty_q[req_set];

    for (genvar w = 0; w < WAYS; w++) begin : g_way
        assign row_ages[w*AGE_W +: AGE_W] = age_q[req_set][w];
        tag_lookup_way_cmp #(.TAG_W(TAG_W)) u_cmp (
            .way_valid (row_valid[w]),
            .way_tag   (tag_q[req_set][w]),
            .req_tag   (req_tag),
            .match     (hit_vec[w])
        );
    end

    logic                free_found;
    logic [WAY_BITS-1:0] free_way;
    logic [WAY_BITS-1:0] victim_way;

    tag_lookup_pick #(.WAYS(WAYS), .WAY_W(WAY_BITS), .AGE_W(AGE_W)) u_pick (
        .valid      (row_valid),
        .ages       (row_ages),
        .free_found (free_found),
        .free_way   (free_way),
        .victim_way (victim_way)
    );

    // Lookup decision
    logic                hit;
    logic [WAY_BITS-1:0] hit_way;
    logic [WAY_BITS-1:0] alloc_way;
    logic                do_alloc;
    op_e                 op;

    always_comb begin
        hit     = |hit_vec;
        hit_way = '0;
        for (int w = WAYS - 1; w >= 0; w--) begin
            if (hit_vec[w]) hit_way = WAY_BITS'(w);
        end
        alloc_way = free_found ? free_way : victim_way;
        do_alloc  = !hit && (!req_write || WRITE_BACK);
        if (!accept)        op = OP_IDLE;
        else if (hit)       op = req_write ? OP_WRITE_HIT  : OP_READ_HIT;
        else                op = req_write ? OP_WRITE_MISS : OP_READ_MISS;
    end

    // Next row contents
    logic [WAYS-1:0]  nxt_valid;
    logic [WAYS-1:0]  nxt_dirty;
    logic [AGE_W-1:0] nxt_age [WAYS];
    logic [TAG_W-1:0] nxt_tag [WAYS];

    always_comb begin
        for (int w = 0; w < WAYS; w++) begin
            nxt_valid[w] = row_valid[w];
            nxt_dirty[w] = row_dirty[w];
            nxt_tag[w]   = tag_q[req_set][w];
            nxt_age[w]   = age_q[req_set][w];
            if (row_valid[w]) begin
                if (hit_vec[w])                   nxt_age[w] = '0;
                else if (nxt_age[w] != AGE_MAX)   nxt_age[w] = nxt_age[w] + 1'b1;
            end
            if (WRITE_BACK && hit_vec[w] && req_write) nxt_dirty[w] = 1'b1;
            if (do_alloc && (alloc_way == WAY_BITS'(w))) begin
                nxt_valid[w] = 1'b1;
                nxt_dirty[w] = WRITE_BACK && req_write;
                nxt_tag[w]   = req_tag;
                nxt_age[w]   = '0;
            end
        end
    end

    // Memory write decision
    logic              mw_valid;
    logic              mw_evict;
    logic [ADDR_W-1:0] mw_addr;
    logic [TAG_W-1:0]  victim_tag;

    assign victim_tag = tag_q[req_set][victim_way];

    always_comb begin
        mw_valid = 1'b0;
        mw_evict = 1'b0;
        mw_addr  = ADDR_W'(line_addr(64'(req_tag), 64'(req_set), 64'(BANK_ID),
                                     LOW_BITS, BANK_BITS, SET_BITS, TAG_W));
        if (!WRITE_BACK) begin
            mw_valid = req_write;
        end else if (do_alloc && !free_found && row_dirty[victim_way]) begin
            mw_valid = 1'b1;
            mw_evict = 1'b1;
            mw_addr  = ADDR_W'(line_addr(64'(victim_tag), 64'(req_set), 64'(BANK_ID),
                                         LOW_BITS, BANK_BITS, SET_BITS, TAG_W));
        end
    end

    // Array update: sweep first, then accepted requests
    logic [SET_BITS-1:0] init_set;
    logic [WAY_BITS-1:0] init_way;
    assign init_set = init_idx[IDX_W-1:WAY_BITS];
    assign init_way = init_idx[WAY_BITS-1:0];

    always_ff @(posedge clk) begin
        if (!rst && init_busy) begin
            valid_q[init_set][init_way] <= 1'b0;
            dirty_q[init_set][init_way] <= 1'b0;
            age_q[init_set][init_way]   <= '0;
            tag_q[init_set][init_way]   <= '0;
        end else if (accept) begin
            valid_q[req_set] <= nxt_valid;
            dirty_q[req_set] <= nxt_dirty;
            for (int w = 0; w < WAYS; w++) begin
                age_q[req_set][w] <= nxt_age[w];
                tag_q[req_set][w] <= nxt_tag[w];
            end
        end
    end

    // Registered response
    always_ff @(posedge clk) begin
        if (rst) begin
            rsp_valid      <= 1'b0;
            rsp_hit        <= 1'b0;
            rsp_hit_way    <= '0;
            rsp_free_found <= 1'b0;
            rsp_free_way   <= '0;
            rsp_victim_way <= '0;
            rsp_alloc_way  <= '0;
            mem_wr_valid   <= 1'b0;
            mem_wr_addr    <= '0;
            mem_wr_evict   <= 1'b0;
            rd_miss_pulse  <= 1'b0;
            wr_miss_pulse  <= 1'b0;
        end else begin
            rsp_valid      <= accept;
            rsp_hit        <= accept && hit;
            rsp_hit_way    <= hit_way;
            rsp_free_found <= free_found;
            rsp_free_way   <= free_way;
            rsp_victim_way <= victim_way;
            rsp_alloc_way  <= alloc_way;
            mem_wr_valid   <= accept && mw_valid;
            mem_wr_addr    <= mw_addr;
            mem_wr_evict   <= accept && mw_evict;
            rd_miss_pulse  <= (op == OP_READ_MISS);
            wr_miss_pulse  <= (op == OP_WRITE_MISS);
        end
    end
endmodule

// File: rtl/tag_lookup_checker.sv
module tag_lookup_checker #(
    parameter bit WRITE_BACK = 1'b1
) (
    input logic clk,
    input logic rst,
    input logic ready,
    input logic req_valid,
    input logic req_write,
    input logic rsp_valid,
    input logic rsp_hit,
    input logic rsp_free_found,
    input logic mem_wr_valid,
    input logic mem_wr_evict,
    input logic rd_miss_pulse,
    input logic wr_miss_pulse
);
    p_no_rsp_when_busy_r1: assert property (@(posedge clk) disable iff (rst)
        !ready |=> !rsp_valid);

    p_ready_holds_r1: assert property (@(posedge clk) disable iff (rst)
        ready |=> ready);

    p_rsp_follows_req_r2: assert property (@(posedge clk) disable iff (rst)
        (req_valid && ready) |=> rsp_valid);

    p_no_spurious_rsp_r2: assert property (@(posedge clk) disable iff (rst)
        !(req_valid && ready) |=> !rsp_valid);

    p_wb_hit_quiet_r7: assert property (@(posedge clk) disable iff (rst)
        (WRITE_BACK && rsp_valid && rsp_hit) |-> !mem_wr_valid);

    p_wt_write_out_r8: assert property (@(posedge clk) disable iff (rst)
        (!WRITE_BACK && req_valid && ready && req_write) |=> mem_wr_valid);

    p_wt_never_evicts_r8: assert property (@(posedge clk) disable iff (rst)
        !WRITE_BACK |-> !mem_wr_evict);

    p_evict_needs_full_set_r9: assert property (@(posedge clk) disable iff (rst)
        mem_wr_evict |-> (mem_wr_valid && !rsp_hit && !rsp_free_found));

    p_miss_pulse_onehot_r11: assert property (@(posedge clk) disable iff (rst)
        $onehot0({rd_miss_pulse, wr_miss_pulse, rsp_hit}));

    p_miss_needs_rsp_r11: assert property (@(posedge clk) disable iff (rst)
        (rd_miss_pulse || wr_miss_pulse) |-> rsp_valid);

    p_read_miss_kind_r11: assert property (@(posedge clk) disable iff (rst)
        rd_miss_pulse |-> !$past(req_write));
endmodule

bind tag_lookup_engine tag_lookup_checker #(.WRITE_BACK(WRITE_BACK)) u_checker (
    .clk            (clk),
    .rst            (rst),
    .ready          (ready),
    .req_valid      (req_valid),
    .req_write      (req_write),
    .rsp_valid      (rsp_valid),
    .rsp_hit        (rsp_hit),
    .rsp_free_found (rsp_free_found),
    .mem_wr_valid   (mem_wr_valid),
    .mem_wr_evict   (mem_wr_evict),
    .rd_miss_pulse  (rd_miss_pulse),
    .wr_miss_pulse  (wr_miss_pulse)
);

// File: tb/tag_lookup_engine_bench.sv
`timescale 1ns/1ps
module tag_lookup_engine_bench;
    localparam int SETS = 8;
    localparam int WAYS = 4;
    localparam int AMAX = 7;
    localparam int LINES = SETS * WAYS;

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #2.5 clk = ~clk;

    logic        req_valid = 1'b0;
    logic [2:0]  req_set   = '0;
    logic [24:0] req_tag   = '0;
    logic        req_write = 1'b0;

    logic [1:0]       o_ready, o_rv, o_hit, o_ff, o_mw, o_ev, o_rm, o_wm;
    logic [1:0][1:0]  o_hw, o_fw, o_vw, o_aw;
    logic [1:0][31:0] o_addr;

    tag_lookup_engine #(.BANK_BITS(1), .BANK_ID(1), .WRITE_BACK(1'b1)) u_tag_lookup_engine (
        .clk(clk), .rst(rst), .ready(o_ready[0]),
        .req_valid(req_valid), .req_set(req_set), .req_tag(req_tag[23:0]), .req_write(req_write),
        .rsp_valid(o_rv[0]), .rsp_hit(o_hit[0]), .rsp_hit_way(o_hw[0]),
        .rsp_free_found(o_ff[0]), .rsp_free_way(o_fw[0]), .rsp_victim_way(o_vw[0]),
        .rsp_alloc_way(o_aw[0]), .mem_wr_valid(o_mw[0]), .mem_wr_addr(o_addr[0]),
        .mem_wr_evict(o_ev[0]), .rd_miss_pulse(o_rm[0]), .wr_miss_pulse(o_wm[0]));

    tag_lookup_engine #(.BANK_BITS(0), .BANK_ID(0), .WRITE_BACK(1'b0)) u_tag_lookup_engine_wt (
        .clk(clk), .rst(rst), .ready(o_ready[1]),
        .req_valid(req_valid), .req_set(req_set), .req_tag(req_tag), .req_write(req_write),
        .rsp_valid(o_rv[1]), .rsp_hit(o_hit[1]), .rsp_hit_way(o_hw[1]),
        .rsp_free_found(o_ff[1]), .rsp_free_way(o_fw[1]), .rsp_victim_way(o_vw[1]),
        .rsp_alloc_way(o_aw[1]), .mem_wr_valid(o_mw[1]), .mem_wr_addr(o_addr[1]),
        .mem_wr_evict(o_ev[1]), .rd_miss_pulse(o_rm[1]), .wr_miss_pulse(o_wm[1]));

    int total = 0;
    int bad   = 0;
    bit done  = 1'b0;

    // Reference line state: index 0 = write-back, 1 = write-through
    bit m_valid [2][SETS][WAYS];
    bit m_dirty [2][SETS][WAYS];
    int m_tag   [2][SETS][WAYS];
    int m_age   [2][SETS][WAYS];

    bit pend [2];
    bit e_hit[2], e_ff[2], e_mw[2], e_ev[2], e_rm[2], e_wm[2];
    int e_hw[2], e_fw[2], e_vw[2], e_aw[2];
    logic [31:0] e_addr [2];

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] addr_of(input int m, input int tag, input int set);
        if (m == 0) return 32'((tag << 8) | (set << 5) | (1 << 4));
        return 32'((tag << 7) | (set << 4));
    endfunction

    task automatic model(input int m, input int s, input int t, input bit wr);
        bit wb = (m == 0);
        bit hit = 0;
        bit ff = 0;
        int hw = 0, fw = 0, vw = 0, best, aw;
        bit alloc;
        for (int w = WAYS - 1; w >= 0; w--) begin
            if (m_valid[m][s][w] && m_tag[m][s][w] == t) begin hit = 1; hw = w; end
            if (!m_valid[m][s][w]) begin ff = 1; fw = w; end
        end
        best = m_age[m][s][0];
        for (int w = 1; w < WAYS; w++)
            if (m_age[m][s][w] > best) begin best = m_age[m][s][w]; vw = w; end
        aw = ff ? fw : vw;
        alloc = !hit && (!wr || wb);
        e_hit[m] = hit; e_hw[m] = hw; e_ff[m] = ff; e_fw[m] = ff ? fw : 0;
        e_vw[m] = vw; e_aw[m] = aw;
        e_mw[m] = 0; e_ev[m] = 0; e_addr[m] = '0;
        if (!wb && wr) begin
            e_mw[m] = 1; e_addr[m] = addr_of(m, t, s);
        end else if (wb && alloc && !ff && m_dirty[m][s][vw]) begin
            e_mw[m] = 1; e_ev[m] = 1; e_addr[m] = addr_of(m, m_tag[m][s][vw], s);
        end
        e_rm[m] = !hit && !wr;
        e_wm[m] = !hit && wr;
        for (int w = 0; w < WAYS; w++) begin
            if (m_valid[m][s][w]) begin
                if (hit && w == hw) m_age[m][s][w] = 0;
                else if (m_age[m][s][w] < AMAX) m_age[m][s][w]++;
            end
        end
        if (wb && hit && wr) m_dirty[m][s][hw] = 1;
        if (alloc) begin
            m_valid[m][s][aw] = 1; m_tag[m][s][aw] = t;
            m_dirty[m][s][aw] = wb && wr; m_age[m][s][aw] = 0;
        end
        pend[m] = 1;
    endtask

    task automatic check_outputs(input int m);
        if (pend[m]) begin
            chk("R2 rsp_valid", o_rv[m], 1);
            chk("R2 hit", o_hit[m], e_hit[m]);
            if (e_hit[m]) chk("R2 hit way", o_hw[m], e_hw[m]);
            chk("R3 free found", o_ff[m], e_ff[m]);
            if (e_ff[m]) chk("R3 free way", o_fw[m], e_fw[m]);
            chk("R4 R5 victim way", o_vw[m], e_vw[m]);
            chk("R6 alloc way", o_aw[m], e_aw[m]);
            chk("R7 R8 R9 mem write", o_mw[m], e_mw[m]);
            if (e_mw[m]) chk("R10 mem addr", o_addr[m], e_addr[m]);
            chk("R9 R8 evict", o_ev[m], e_ev[m]);
            chk("R11 read miss", o_rm[m], e_rm[m]);
            chk("R11 write miss", o_wm[m], e_wm[m]);
        end else begin
            chk("R2 idle rsp_valid", o_rv[m], 0);
            chk("R11 idle pulses", {o_rm[m], o_wm[m], o_mw[m]}, 0);
        end
        pend[m] = 0;
    endtask

    // One cycle: check the previous request's response, then drive the next.
    task automatic cyc(input bit v, input int s, input int t, input bit wr);
        @(negedge clk);
        check_outputs(0);
        check_outputs(1);
        req_valid = v; req_set = 3'(s); req_tag = 25'(t); req_write = wr;
        if (v) begin
            model(0, s, t, wr);
            model(1, s, t, wr);
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog expired");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240611));
        for (int m = 0; m < 2; m++)
            for (int s = 0; s < SETS; s++)
                for (int w = 0; w < WAYS; w++) begin
                    m_valid[m][s][w] = 0; m_dirty[m][s][w] = 0;
                    m_tag[m][s][w] = 0;   m_age[m][s][w] = 0;
                end
        pend[0] = 0; pend[1] = 0;
        repeat (3) @(negedge clk);
        chk("R1 reset no response", o_rv, 0);
        rst = 1'b0;
        // R1: requests during the sweep are ignored; ready rises after LINES cycles
        req_valid = 1'b1; req_set = 3'd0; req_tag = 25'd7; req_write = 1'b0;
        for (int k = 1; k <= LINES; k++) begin
            @(negedge clk);
            if (k == LINES - 1 || k == LINES)
                chk("R1 ready timing", o_ready, (k == LINES) ? 2'b11 : 2'b00);
            chk("R1 no response while sweeping", o_rv, 0);
            if (k == LINES) req_valid = 1'b0;
        end

        // Set 0 must still be empty (R1): read tag 7 misses into way 0
        cyc(1, 0, 7, 0);
        cyc(1, 0, 7, 0);
        // Saturation: fill set 1 then hit way 0 six times (R5, R4)
        for (int i = 1; i <= 4; i++) cyc(1, 1, i, 0);
        for (int i = 0; i < 6; i++) cyc(1, 1, 1, 0);
        cyc(1, 1, 9, 0);
        // Dirty eviction (R9) in write-back, write forwarding (R8) in write-through
        for (int i = 1; i <= 4; i++) cyc(1, 2, i, 1);
        cyc(1, 2, 5, 1);
        cyc(1, 2, 1, 0);
        // Write hit (R7 / R8)
        cyc(1, 3, 3, 0);
        cyc(1, 3, 3, 1);
        cyc(0, 0, 0, 0);
        // Large tag exercising the upper address bits (R10)
        cyc(1, 7, 24'hABCDE5, 1);
        cyc(1, 7, 24'hABCDE5, 0);

        // Random traffic on few sets with a small tag pool
        for (int i = 0; i < 4000; i++) begin
            int r = int'($urandom_range(0, 99));
            int s = (r < 70) ? int'($urandom_range(0, 2)) : int'($urandom_range(0, 7));
            int t = (int'($urandom_range(0, 9)) == 0) ? int'($urandom_range(0, 24'hFFFFFF))
                                                      : int'($urandom_range(0, 6));
            cyc(int'($urandom_range(0, 9)) < 7, s, t, int'($urandom_range(0, 9)) < 4);
        end
        cyc(0, 0, 0, 0);
        cyc(0, 0, 0, 0);

        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule